// File: doc/BRIEF.md
# Multi-mode 8-bit timer channel

One channel of a peripheral timer. An 8-bit down-counter is paired with an 8-bit reload register, and a control write selects one of four operating modes together with a 3-bit prescale code. In delay mode the counter steps down once per prescaled clock period. In event-count mode it steps down once per active edge of an external input. In pulse-width mode it steps down once per prescaled period, but only while that external input is held at its active level. In stopped mode it holds.

Software writes the data port to set the reload value and reads the live count at any time. Each time the counter runs out, it reloads and raises a one-cycle timeout pulse, which the interrupt logic of the wider peripheral consumes. The bus decoding that produces the write strobes sits outside this block.

Top module: `tmr8_channel`

## Requirements
- R1: After reset the count is 0, the timeout pulse is low and the mode is stopped, so the count holds until written.
- R2: In stopped mode (ctrl_mode 0) a data write loads both the reload register and the counter, and count_q reads the new value in the next cycle. With no write, the count does not change.
- R3: While the timer is running, a data write changes only the reload register and leaves count_q unchanged. The next reload uses the new value, including a reload that happens in the same cycle as the write.
- R4: In delay mode (ctrl_mode 1) the count decreases by one every D clock cycles. The first step comes D cycles after the control write. D is set by prescale code 1..7 as 4, 10, 16, 50, 64, 100, 200. Code 0 stops counting.
- R5: A step taken from a count of 1 loads the counter from the reload register and raises timeout_p for exactly one cycle, in the same cycle that count_q shows the reloaded value.
- R6: A reload value of 0 gives a period of 256 steps: the first step goes from 0 to 255.
- R7: In event-count mode (ctrl_mode 2) each rising edge of ext_in takes one step. A level held high takes no further steps. The prescale code has no effect in this mode.
- R8: In pulse-width mode (ctrl_mode 3) prescaled steps occur only while ext_in is high. While ext_in is low both the count and the partial prescale progress are frozen.
- R9: A control write restarts the prescaler. With ctrl_reset set it also loads the counter from the reload register; with ctrl_reset clear the count is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_mode | input | 2 | Mode: 0 stopped, 1 delay, 2 event count, 3 pulse-width |
| ctrl_psc | input | 3 | Prescale code, 0 means no prescaled steps |
| ctrl_reset | input | 1 | With ctrl_we, load the counter from the reload register |
| data_we | input | 1 | Data write strobe |
| data_wdata | input | 8 | Value for the reload register |
| ext_in | input | 1 | External event/gate input, active high |
| count_q | output | 8 | Live count |
| timeout_p | output | 1 | One-cycle pulse on reload after underflow |

## Verification
Two functions can fall in the same cycle: a data write while the timer runs, and the underflow reload. The bench lines the write strobe up on the exact cycle in which the counter steps from 1. It then expects the reloaded count to equal the newly written value rather than the old one, and expects the timeout pulse to be high in that same sample. A control write is also placed in the middle of a run, with and without the reset flag, to check that the restart of the prescaler and the reload agree on the cycle of the next step.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

   typedef enum logic [1:0] {
      MODE_STOP  = 2'd0,
      MODE_DELAY = 2'd1,
      MODE_EVENT = 2'd2,
      MODE_PULSE = 2'd3
   } tmr_mode_e;

   localparam int unsigned DIV_MAX = 200;

   // Prescale divide ratio for a 3-bit code; code 0 yields 0 (no ticks).
   function automatic int unsigned psc_div(input logic [2:0] code);
      case (code)
         3'd1:    return 4;
         3'd2:    return 10;
         3'd3:    return 16;
         3'd4:    return 50;
         3'd5:    return 64;
         3'd6:    return 100;
         3'd7:    return 200;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
   parameter int PW = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       enable,
   input  logic [2:0] code,
   output logic       tick
);
   import tmr8_pkg::*;

   logic [PW-1:0] pcnt;
   logic [PW-1:0] limit;
   logic          active;

   always_comb begin
      limit  = PW'(psc_div(code) - 1);
      active = enable && (code != 3'd0);
      tick   = active && (pcnt == limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pcnt <= '0;
      else if (clear)
         pcnt <= '0;
      else if (active)
         pcnt <= tick ? '0 : pcnt + 1'b1;
   end

endmodule

// File: rtl/tmr8_input_edge.sv
module tmr8_input_edge #(
   parameter bit EDGE_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_in,
   output logic evt,
   output logic gate
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= ~EDGE_RISE;
      else        prev <= ext_in;
   end

   generate
      if (EDGE_RISE) begin : g_rise
         assign evt  = ext_in & ~prev;
         assign gate = ext_in;
      end else begin : g_fall
         assign evt  = ~ext_in & prev;
         assign gate = ~ext_in;
      end
   endgenerate

endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rel_we,
   input  logic [CNT_W-1:0] rel_wdata,
   input  logic             load_cnt,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             timeout
);
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] reload_nx;

   assign reload_nx = rel_we ? rel_wdata : reload_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         cnt      <= '0;
         timeout  <= 1'b0;
      end else begin
         reload_q <= reload_nx;
         timeout  <= 1'b0;
         if (load_cnt) begin
            cnt <= reload_nx;
         end else if (dec) begin
            if (cnt == CNT_W'(1)) begin
               cnt     <= reload_nx;
               timeout <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/tmr8_channel.sv
module tmr8_channel #(
   parameter int CNT_W     = 8,
   parameter bit EDGE_RISE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we,
   input  logic [1:0]       ctrl_mode,
   input  logic [2:0]       ctrl_psc,
   input  logic             ctrl_reset,
   input  logic             data_we,
   input  logic [CNT_W-1:0] data_wdata,
   input  logic             ext_in,
   output logic [CNT_W-1:0] count_q,
   output logic             timeout_p
);
   import tmr8_pkg::*;

   localparam int PW = $clog2(DIV_MAX);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("tmr8_channel: CNT_W must be at least 2");
      end
      if ((1 << PW) < DIV_MAX) begin : g_bad_psc
         $error("tmr8_channel: prescaler width too small");
      end
   endgenerate

   tmr_mode_e  mode_q;
   logic [2:0] psc_q;
   logic       evt, gate, tick, dec, load_cnt, psc_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_STOP;
         psc_q  <= 3'd0;
      end else if (ctrl_we) begin
         mode_q <= tmr_mode_e'(ctrl_mode);
         psc_q  <= ctrl_psc;
      end
   end

   tmr8_input_edge #(.EDGE_RISE(EDGE_RISE)) u_edge (
      .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .evt(evt), .gate(gate)
   );

   assign psc_en = (mode_q == MODE_DELAY) || ((mode_q == MODE_PULSE) && gate);

   tmr8_prescaler #(.PW(PW)) u_psc (
      .clk(clk), .rst_n(rst_n), .clear(ctrl_we), .enable(psc_en),
      .code(psc_q), .tick(tick)
   );

   assign dec      = !ctrl_we && (tick || ((mode_q == MODE_EVENT) && evt));
   assign load_cnt = (ctrl_we && ctrl_reset) || (data_we && (mode_q == MODE_STOP));

   tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .rel_we(data_we), .rel_wdata(data_wdata),
      .load_cnt(load_cnt), .dec(dec), .cnt(count_q), .timeout(timeout_p)
   );

endmodule

// File: rtl/tmr8_channel_chk.sv
module tmr8_channel_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctrl_we,
   input logic             data_we,
   input logic             ext_in,
   input logic [1:0]       mode_q,
   input logic [CNT_W-1:0] count_q,
   input logic             timeout_p
);
   logic quiet;
   assign quiet = !ctrl_we && !data_we;

   assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd0 && quiet) |=> $stable(count_q));

   assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> (count_q == $past(count_q) || count_q == $past(count_q) - 1'b1 || timeout_p));

   assert_pulse_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_p |=> !timeout_p);

   assert_underflow_from_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_p) |-> $past(count_q) == CNT_W'(1));

   assert_event_low_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd2 && !ext_in && quiet) |=> $stable(count_q));

   assert_gate_low_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd3 && !ext_in && quiet) |=> $stable(count_q));

endmodule

bind tmr8_channel tmr8_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .data_we(data_we),
   .ext_in(ext_in), .mode_q(mode_q), .count_q(count_q), .timeout_p(timeout_p)
);

// File: tb/tmr8_channel_tb.sv
`timescale 1ns/1ps
module tmr8_channel_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctrl_we = 1'b0;
   logic [1:0] ctrl_mode = 2'd0;
   logic [2:0] ctrl_psc = 3'd0;
   logic       ctrl_reset = 1'b0;
   logic       data_we = 1'b0;
   logic [7:0] data_wdata = 8'd0;
   logic       ext_in = 1'b0;
   logic [7:0] count_q;
   logic       timeout_p;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tmr8_channel u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_mode(ctrl_mode),
      .ctrl_psc(ctrl_psc), .ctrl_reset(ctrl_reset), .data_we(data_we),
      .data_wdata(data_wdata), .ext_in(ext_in), .count_q(count_q),
      .timeout_p(timeout_p)
   );

   function automatic int exp_div(input int code);
      case (code)
         1: return 4;   2: return 10;  3: return 16;  4: return 50;
         5: return 64;  6: return 100; 7: return 200; default: return 0;
      endcase
   endfunction

   function automatic int exp_period(input int n, input int code);
      return ((n == 0) ? 256 : n) * exp_div(code);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_ctrl(input int mode, input int code, input bit rst);
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_mode = 2'(mode); ctrl_psc = 3'(code); ctrl_reset = rst;
      @(negedge clk);
      ctrl_we = 1'b0; ctrl_reset = 1'b0;
   endtask

   task automatic wr_data(input int v);
      @(negedge clk);
      data_we = 1'b1; data_wdata = 8'(v);
      @(negedge clk);
      data_we = 1'b0;
   endtask

   task automatic measure(input int limit, output int k, output int cnt);
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!timeout_p && k < limit);
      cnt = count_q;
   endtask

   task automatic pulse_ext();
      @(negedge clk); ext_in = 1'b1;
      @(negedge clk); ext_in = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int k, c, n, code, seed;
      seed = $urandom(32'd4242);
      wait_cyc(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 count", count_q, 0);
      chk("R1 timeout", timeout_p, 0);
      wait_cyc(5);
      chk("R1 hold", count_q, 0);

      // R2: stopped write loads counter
      wr_data(5);
      chk("R2 load", count_q, 5);
      wait_cyc(3);
      chk("R2 hold", count_q, 5);

      // R4/R5: delay, code 1
      wr_ctrl(1, 1, 1'b0);
      wait_cyc(4);
      chk("R4 first step", count_q, 4);
      measure(100, k, c);
      chk("R5 period", k + 4, 20);
      chk("R5 reload", c, 5);
      @(negedge clk);
      chk("R5 one cycle", timeout_p, 0);

      // R4: random periods across codes
      for (int i = 0; i < 6; i++) begin
         n = $urandom_range(1, 12);
         code = $urandom_range(1, 7);
         wr_ctrl(0, 0, 1'b0);
         wr_data(n);
         wr_ctrl(1, code, 1'b0);
         measure(5000, k, c);
         chk($sformatf("R4 period code %0d n %0d", code, n), k, exp_period(n, code));
         chk("R5 reload random", c, n);
      end

      // R4: code 0 does not count
      wr_ctrl(1, 0, 1'b0);
      c = count_q;
      wait_cyc(300);
      chk("R4 code0 hold", count_q, c);

      // R6: reload 0 = 256 steps
      wr_ctrl(0, 0, 1'b0);
      wr_data(0);
      wr_ctrl(1, 1, 1'b0);
      wait_cyc(4);
      chk("R6 wrap", count_q, 255);
      measure(2000, k, c);
      chk("R6 period", k + 4, exp_period(0, 1));

      // R3: running write only touches reload
      wr_ctrl(0, 0, 1'b0);
      wr_data(10);
      wr_ctrl(1, 1, 1'b0);
      @(negedge clk);
      data_we = 1'b1; data_wdata = 8'd3;
      @(negedge clk);
      data_we = 1'b0;
      chk("R3 count kept", count_q, 10);
      measure(100, k, c);
      chk("R3 new reload", c, 3);

      // R3: write in the same cycle as the underflow
      wr_ctrl(0, 0, 1'b0);
      wr_data(2);
      wr_ctrl(1, 1, 1'b0);
      wait_cyc(7);
      data_we = 1'b1; data_wdata = 8'd9;
      @(negedge clk);
      data_we = 1'b0;
      chk("R3 same-cycle timeout", timeout_p, 1);
      chk("R3 same-cycle reload", count_q, 9);

      // R9: control write with and without reset
      wr_ctrl(0, 0, 1'b0);
      wr_data(9);
      wr_ctrl(1, 1, 1'b0);
      wait_cyc(8);
      chk("R4 two steps", count_q, 7);
      wr_ctrl(1, 1, 1'b1);
      chk("R9 reset load", count_q, 9);
      wait_cyc(8);
      chk("R9 restart", count_q, 7);
      wr_ctrl(1, 1, 1'b0);
      chk("R9 keep", count_q, 7);

      // R7: event count
      wr_ctrl(0, 0, 1'b0);
      wr_data(3);
      wr_ctrl(2, 7, 1'b0);
      pulse_ext();
      chk("R7 one edge", count_q, 2);
      @(negedge clk); ext_in = 1'b1;
      wait_cyc(5);
      ext_in = 1'b0;
      @(negedge clk);
      chk("R7 level", count_q, 1);
      ext_in = 1'b1;
      @(negedge clk);
      chk("R7 timeout", timeout_p, 1);
      chk("R7 reload", count_q, 3);
      ext_in = 1'b0;
      for (int i = 0; i < 5; i++) begin
         wait_cyc($urandom_range(1, 6));
         pulse_ext();
      end
      chk("R7 random edges", count_q, 1);

      // R8: pulse-width gating
      wr_ctrl(0, 0, 1'b0);
      wr_data(3);
      wr_ctrl(3, 1, 1'b0);
      wait_cyc(20);
      chk("R8 gate low", count_q, 3);
      ext_in = 1'b1;
      wait_cyc(4);
      chk("R8 gated step", count_q, 2);
      ext_in = 1'b0;
      wait_cyc(10);
      chk("R8 frozen", count_q, 2);
      ext_in = 1'b1;
      wait_cyc(2);
      ext_in = 1'b0;
      wait_cyc(5);
      chk("R8 partial", count_q, 2);
      ext_in = 1'b1;
      wait_cyc(2);
      ext_in = 1'b0;
      @(negedge clk);
      chk("R8 resumed", count_q, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule